// File: doc/BRIEF.md
# Relocatable Memory Map Decoder

This block turns a 16-bit address into at most one chip select among internal RAM, a 64-byte control-register block, a boot ROM, an EEPROM and an EPROM, or into an enable for the external bus. It is purely combinational from the address to the selects. A single 8-bit mapping register is the only state. That register picks the 4-Kbyte page for the RAM window and, separately, the page for the register window.

The operating mode decides two things: whether the boot ROM is in the map, and whether an address that no on-chip resource claims goes out to the external bus. Two configuration inputs remove the EEPROM and the EPROM from the map, each on its own. The mapping register can be written only during a short interval after reset. After that interval the map is fixed until the next reset.

Top module: `memmap_decoder`

## Requirements
- R1: After reset the mapping register holds 8'h01. With the default parameters, RAM is then selected for 16'h0000–16'h01FF and the register block for 16'h1000–16'h103F.
- R2: A write to the mapping register puts the RAM page in bits [7:4] and the register page in bits [3:0]. RAM then decodes at {page,12'h000} up to 512 bytes, and registers at {page,12'h000} up to 64 bytes. The new map applies from the cycle after the write edge.
- R3: A write is accepted only on one of the first 64 rising clock edges after reset is released. Any later write leaves the map unchanged.
- R4: Where the register window and the RAM window overlap, only the register select is active, so the first 64 bytes of that RAM page cannot be reached.
- R5: The boot ROM is selected for 16'hBF00–16'hBFFF only when mode is 2'b10 (bootstrap). boot_vec is high exactly for boot ROM accesses in 16'hBFC0–16'hBFFF.
- R6: The EEPROM is selected for 16'hB600–16'hB7FF only while cfg_eeprom_en is 1.
- R7: The EPROM is selected for 16'hD000–16'hFFFF only while cfg_eprom_en is 1.
- R8: Mode encoding: 2'b00 single-chip, 2'b01 expanded, 2'b10 bootstrap, 2'b11 test. ext_en is high only in modes 2'b01 and 2'b11, and only when no on-chip select is active. On-chip selects are the same in single-chip and expanded modes.
- R9: Priority is register, RAM, boot ROM, EEPROM, EPROM, external. At most one of the six outputs is active for any address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Address to decode |
| mode | input | 2 | Operating mode (encoding in R8) |
| cfg_eprom_en | input | 1 | EPROM decode enable |
| cfg_eeprom_en | input | 1 | EEPROM decode enable |
| map_wr_en | input | 1 | Mapping register write strobe |
| map_wr_data | input | 8 | Mapping value: RAM page [7:4], register page [3:0] |
| sel_reg | output | 1 | Register block select |
| sel_ram | output | 1 | RAM select |
| sel_boot | output | 1 | Boot ROM select |
| sel_eeprom | output | 1 | EEPROM select |
| sel_eprom | output | 1 | EPROM select |
| ext_en | output | 1 | External bus enable |
| boot_vec | output | 1 | Boot ROM access falls in the vector area |

## Verification
The mapping register is the only state. If it is wrong, the RAM or register selects move to the wrong page in the very next cycle, and that shows on any address in either window. If the write window closes late, a late write relocates the pages, and the next decode in the old or new page catches it. If it closes early, an early write is lost and the same decode catches it. A priority or enable error shows on the same cycle: two selects active at once, or a select that should be active staying low.

// File: rtl/memmap_pkg.sv
package memmap_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE   = 2'b00,
    MODE_EXPANDED = 2'b01,
    MODE_BOOT     = 2'b10,
    MODE_TEST     = 2'b11
  } mode_e;

  localparam int unsigned PAGE_BITS = 4;
  localparam int unsigned PAGE_SPAN = 4096;
  localparam int unsigned NREGION   = 5;

  localparam int unsigned IDX_REG    = 0;
  localparam int unsigned IDX_RAM    = 1;
  localparam int unsigned IDX_BOOT   = 2;
  localparam int unsigned IDX_EEPROM = 3;
  localparam int unsigned IDX_EPROM  = 4;

  function automatic logic in_range(input logic [15:0] a,
                                    input int unsigned base,
                                    input int unsigned bytes);
    int unsigned av;
    av = {16'd0, a};
    return (av >= base) && (av < base + bytes);
  endfunction

  function automatic int unsigned page_base(input logic [PAGE_BITS-1:0] pg);
    return int'(pg) * PAGE_SPAN;
  endfunction

  function automatic logic mode_has_ext(input mode_e m);
    return (m == MODE_EXPANDED) || (m == MODE_TEST);
  endfunction

endpackage

// File: rtl/memmap_initreg.sv
module memmap_initreg #(
  parameter logic [7:0]  RESET_VAL = 8'h01,
  parameter int unsigned WINDOW    = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] map_q,
  output logic       window_open
);
  localparam int unsigned CW = $clog2(WINDOW + 1);

  logic [CW-1:0] age_q;

  assign window_open = (age_q < CW'(WINDOW));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q <= '0;
    end else if (window_open) begin
      age_q <= age_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q <= RESET_VAL;
    end else if (wr_en && window_open) begin
      map_q <= wr_data;
    end
  end
endmodule

// File: rtl/memmap_window.sv
module memmap_window
  import memmap_pkg::*;
#(
  parameter bit          RELOC = 1'b0,
  parameter int unsigned BASE  = 0,
  parameter int unsigned BYTES = 256
) (
  input  logic [15:0]          addr,
  input  logic [PAGE_BITS-1:0] page,
  input  logic                 enable,
  output logic                 hit
);
  int unsigned base_eff;

  always_comb begin
    base_eff = RELOC ? page_base(page) : BASE;
    hit      = enable && in_range(addr, base_eff, BYTES);
  end
endmodule

// File: rtl/memmap_arbiter.sv
module memmap_arbiter
  import memmap_pkg::*;
#(
  parameter int unsigned N = NREGION
) (
  input  logic [N-1:0] hits,
  input  logic         ext_allowed,
  output logic [N-1:0] grant,
  output logic         ext_en
);
  logic [N:0] taken;

  assign taken[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_prio
    assign grant[i]   = hits[i] && !taken[i];
    assign taken[i+1] = taken[i] || hits[i];
  end

  assign ext_en = ext_allowed && !taken[N];
endmodule

// File: rtl/memmap_decoder.sv
module memmap_decoder
  import memmap_pkg::*;
#(
  parameter int unsigned RAM_BYTES     = 512,
  parameter int unsigned REG_BYTES     = 64,
  parameter int unsigned BOOT_BASE     = 32'h0000_BF00,
  parameter int unsigned BOOT_BYTES    = 256,
  parameter int unsigned BOOT_VEC_OFS  = 32'h0000_00C0,
  parameter int unsigned EEPROM_BASE   = 32'h0000_B600,
  parameter int unsigned EEPROM_BYTES  = 512,
  parameter int unsigned EPROM_BASE    = 32'h0000_D000,
  parameter int unsigned EPROM_BYTES   = 12288,
  parameter logic [7:0]  MAP_RESET     = 8'h01,
  parameter int unsigned WRITE_WINDOW  = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] addr,
  input  logic [1:0]  mode,
  input  logic        cfg_eprom_en,
  input  logic        cfg_eeprom_en,
  input  logic        map_wr_en,
  input  logic [7:0]  map_wr_data,
  output logic        sel_reg,
  output logic        sel_ram,
  output logic        sel_boot,
  output logic        sel_eeprom,
  output logic        sel_eprom,
  output logic        ext_en,
  output logic        boot_vec
);
  localparam logic [PAGE_BITS-1:0] NO_PAGE = '0;

  mode_e                mode_q;
  logic [7:0]           map_q;
  logic                 window_open;
  logic [PAGE_BITS-1:0] ram_page;
  logic [PAGE_BITS-1:0] reg_page;
  logic                 boot_mode;
  logic                 hit_reg_raw;
  logic                 hit_ram_raw;
  logic                 hit_boot_raw;
  logic                 hit_eeprom_raw;
  logic                 hit_eprom_raw;
  logic                 hit_vec_raw;
  logic [NREGION-1:0]   hits;
  logic [NREGION-1:0]   grant;

  assign mode_q    = mode_e'(mode);
  assign boot_mode = (mode_q == MODE_BOOT);
  assign ram_page  = map_q[7:4];
  assign reg_page  = map_q[3:0];

  memmap_initreg #(
    .RESET_VAL (MAP_RESET),
    .WINDOW    (WRITE_WINDOW)
  ) u_initreg (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (map_wr_en),
    .wr_data     (map_wr_data),
    .map_q       (map_q),
    .window_open (window_open)
  );

  memmap_window #(.RELOC(1'b1), .BASE(0), .BYTES(REG_BYTES)) u_win_reg (
    .addr(addr), .page(reg_page), .enable(1'b1), .hit(hit_reg_raw));

  memmap_window #(.RELOC(1'b1), .BASE(0), .BYTES(RAM_BYTES)) u_win_ram (
    .addr(addr), .page(ram_page), .enable(1'b1), .hit(hit_ram_raw));

  memmap_window #(.RELOC(1'b0), .BASE(BOOT_BASE), .BYTES(BOOT_BYTES)) u_win_boot (
    .addr(addr), .page(NO_PAGE), .enable(boot_mode), .hit(hit_boot_raw));

  memmap_window #(.RELOC(1'b0), .BASE(BOOT_BASE + BOOT_VEC_OFS),
                  .BYTES(BOOT_BYTES - BOOT_VEC_OFS)) u_win_vec (
    .addr(addr), .page(NO_PAGE), .enable(boot_mode), .hit(hit_vec_raw));

  memmap_window #(.RELOC(1'b0), .BASE(EEPROM_BASE), .BYTES(EEPROM_BYTES)) u_win_eeprom (
    .addr(addr), .page(NO_PAGE), .enable(cfg_eeprom_en), .hit(hit_eeprom_raw));

  memmap_window #(.RELOC(1'b0), .BASE(EPROM_BASE), .BYTES(EPROM_BYTES)) u_win_eprom (
    .addr(addr), .page(NO_PAGE), .enable(cfg_eprom_en), .hit(hit_eprom_raw));

  always_comb begin
    hits             = '0;
    hits[IDX_REG]    = hit_reg_raw;
    hits[IDX_RAM]    = hit_ram_raw;
    hits[IDX_BOOT]   = hit_boot_raw;
    hits[IDX_EEPROM] = hit_eeprom_raw;
    hits[IDX_EPROM]  = hit_eprom_raw;
  end

  memmap_arbiter #(.N(NREGION)) u_arb (
    .hits        (hits),
    .ext_allowed (mode_has_ext(mode_q)),
    .grant       (grant),
    .ext_en      (ext_en)
  );

  assign sel_reg    = grant[IDX_REG];
  assign sel_ram    = grant[IDX_RAM];
  assign sel_boot   = grant[IDX_BOOT];
  assign sel_eeprom = grant[IDX_EEPROM];
  assign sel_eprom  = grant[IDX_EPROM];
  assign boot_vec   = grant[IDX_BOOT] && hit_vec_raw;
endmodule

// File: rtl/memmap_checker.sv
module memmap_checker #(
  parameter int unsigned WINDOW = 64
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       cfg_eprom_en,
  input logic       cfg_eeprom_en,
  input logic       map_wr_en,
  input logic [7:0] map_q,
  input logic       hit_reg_raw,
  input logic       hit_ram_raw,
  input logic       sel_reg,
  input logic       sel_ram,
  input logic       sel_boot,
  input logic       sel_eeprom,
  input logic       sel_eprom,
  input logic       ext_en,
  input logic       boot_vec
);
  localparam int unsigned CW = $clog2(WINDOW + 1);
  logic [CW-1:0] seen_q;
  logic          closed;

  assign closed = (seen_q >= CW'(WINDOW));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= '0;
    else if (!closed) seen_q <= seen_q + 1'b1;
  end

  p_late_write_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (closed && map_wr_en) |=> $stable(map_q));

  p_reg_over_ram_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_reg_raw && hit_ram_raw) |-> (sel_reg && !sel_ram));

  p_boot_only_in_boot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sel_boot |-> (mode == 2'b10));

  p_vec_inside_boot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    boot_vec |-> sel_boot);

  p_eeprom_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_eeprom_en |-> !sel_eeprom);

  p_eprom_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_eprom_en |-> !sel_eprom);

  p_ext_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ext_en |-> mode[0]);

  p_one_select_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_reg, sel_ram, sel_boot, sel_eeprom, sel_eprom, ext_en}));
endmodule

bind memmap_decoder memmap_checker #(.WINDOW(WRITE_WINDOW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mode          (mode),
  .cfg_eprom_en  (cfg_eprom_en),
  .cfg_eeprom_en (cfg_eeprom_en),
  .map_wr_en     (map_wr_en),
  .map_q         (map_q),
  .hit_reg_raw   (hit_reg_raw),
  .hit_ram_raw   (hit_ram_raw),
  .sel_reg       (sel_reg),
  .sel_ram       (sel_ram),
  .sel_boot      (sel_boot),
  .sel_eeprom    (sel_eeprom),
  .sel_eprom     (sel_eprom),
  .ext_en        (ext_en),
  .boot_vec      (boot_vec)
);

// File: tb/tb_memmap_decoder.sv
module tb_memmap_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [1:0]  mode = 2'b00;
  logic        cfg_eprom_en = 1'b1;
  logic        cfg_eeprom_en = 1'b1;
  logic        map_wr_en = 1'b0;
  logic [7:0]  map_wr_data = '0;
  logic        sel_reg, sel_ram, sel_boot, sel_eeprom, sel_eprom, ext_en, boot_vec;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] m_map;
  int         m_age;

  always #2 clk = ~clk;

  memmap_decoder dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .mode(mode),
    .cfg_eprom_en(cfg_eprom_en), .cfg_eeprom_en(cfg_eeprom_en),
    .map_wr_en(map_wr_en), .map_wr_data(map_wr_data),
    .sel_reg(sel_reg), .sel_ram(sel_ram), .sel_boot(sel_boot),
    .sel_eeprom(sel_eeprom), .sel_eprom(sel_eprom), .ext_en(ext_en),
    .boot_vec(boot_vec)
  );

  // Bench model of the mapping register (R1, R2, R3)
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_map <= 8'h01;
      m_age <= 0;
    end else begin
      if (map_wr_en && m_age < 64) m_map <= map_wr_data;
      if (m_age < 64) m_age <= m_age + 1;
    end
  end

  // Expected {reg, ram, boot, eeprom, eprom, ext, vec}
  function automatic logic [6:0] expect_sel(input logic [15:0] a, input logic [1:0] md,
                                            input logic ep, input logic ee,
                                            input logic [7:0] mp);
    logic [6:0] r;
    r = '0;
    if (a[15:12] == mp[3:0] && a[11:0] < 12'd64)       r[6] = 1'b1;
    else if (a[15:12] == mp[7:4] && a[11:0] < 12'd512) r[5] = 1'b1;
    else if (md == 2'b10 && a[15:8] == 8'hBF) begin
      r[4] = 1'b1;
      r[0] = (a[7:6] == 2'b11);
    end
    else if (ee && a >= 16'hB600 && a <= 16'hB7FF)     r[3] = 1'b1;
    else if (ep && a >= 16'hD000)                       r[2] = 1'b1;
    else if (md == 2'b01 || md == 2'b11)                r[1] = 1'b1;
    return r;
  endfunction

  task automatic check(input string tag, input logic [15:0] a);
    logic [6:0] got, exp;
    addr = a;
    #1;
    got = {sel_reg, sel_ram, sel_boot, sel_eeprom, sel_eprom, ext_en, boot_vec};
    exp = expect_sel(a, mode, cfg_eprom_en, cfg_eeprom_en, m_map);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s addr=%h mode=%b actual=%b expected=%b", tag, a, mode, got, exp);
    end
    @(negedge clk);
  endtask

  task automatic do_reset();
    map_wr_en = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic do_write(input logic [7:0] v);
    map_wr_en = 1'b1;
    map_wr_data = v;
    @(negedge clk);
    map_wr_en = 1'b0;
  endtask

  function automatic logic [15:0] pick_addr();
    logic [15:0] a;
    int k;
    k = $urandom_range(0, 5);
    case (k)
      0: a = {m_map[3:0], 12'h000} + 16'($urandom_range(0, 3)) + (($urandom_range(0,1) != 0) ? 16'd62 : 16'd0);
      1: a = {m_map[7:4], 12'h000} + 16'($urandom_range(0, 520));
      2: a = 16'hBF00 + 16'($urandom_range(0, 255));
      3: a = 16'hB5F0 + 16'($urandom_range(0, 560));
      4: a = 16'hCFF0 + 16'($urandom_range(0, 32));
      default: a = 16'($urandom());
    endcase
    return a;
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d2c));
    @(negedge clk);
    do_reset();
    // R1 reset map, single-chip mode
    check("R1", 16'h0000);
    check("R1", 16'h01FF);
    check("R1", 16'h0200);
    check("R1", 16'h1000);
    check("R1", 16'h103F);
    check("R1", 16'h1040);
    // R2 relocate both to page 3 (R4 overlap)
    do_write(8'h33);
    check("R2", 16'h3000);
    check("R4", 16'h303F);
    check("R4", 16'h3040);
    check("R2", 16'h31FF);
    check("R2", 16'h0000);
    check("R2", 16'h1000);
    // R3 late write ignored
    repeat (70) @(negedge clk);
    do_write(8'h5A);
    check("R3", 16'h3000);
    check("R3", 16'h5000);
    check("R3", 16'hA000);
    // R5 boot ROM and vector area
    mode = 2'b10;
    check("R5", 16'hBF00);
    check("R5", 16'hBFBF);
    check("R5", 16'hBFC0);
    check("R5", 16'hBFFF);
    mode = 2'b00;
    check("R5", 16'hBFC0);
    // R6, R7 enables
    check("R6", 16'hB600);
    check("R6", 16'hB7FF);
    cfg_eeprom_en = 1'b0;
    check("R6", 16'hB700);
    cfg_eeprom_en = 1'b1;
    check("R7", 16'hD000);
    check("R7", 16'hFFFF);
    cfg_eprom_en = 1'b0;
    check("R7", 16'hE000);
    // R8 external bus only in expanded / test
    mode = 2'b01;
    check("R8", 16'hE000);
    check("R8", 16'h3100);
    mode = 2'b11;
    check("R8", 16'h8000);
    mode = 2'b00;
    check("R8", 16'h8000);
    cfg_eprom_en = 1'b1;
    // Random rounds (R9 priority and exclusivity across all modes)
    for (int round = 0; round < 12; round++) begin
      do_reset();
      repeat ($urandom_range(0, 40)) @(negedge clk);
      if (round % 3 == 0) do_write({4'hB, 4'($urandom())});
      else do_write(8'($urandom()));
      for (int i = 0; i < 250; i++) begin
        mode = 2'($urandom());
        cfg_eprom_en = 1'($urandom());
        cfg_eeprom_en = 1'($urandom());
        check("R9", pick_addr());
      end
      do_write(8'($urandom()));
      for (int i = 0; i < 40; i++) check("R3", pick_addr());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule